// File: doc/BRIEF.md
# Read-Modify-Write Increment Bus Sequencer

This block replays, clock by clock, the bus traffic that an 8-bit processor produces when it executes its absolute-addressed memory increment instruction. A one-cycle start pulse hands it a program counter. It then spends six consecutive clocks on the bus. Three reads fetch the instruction bytes. A fourth read fetches the target byte. Two writes follow. The first write stores the unchanged byte back, and the second stores the byte plus one. The block is meant for bus-level modelling and for co-simulation work where every clock must show a real access, so no cycle in a run is idle.

The memory side is a plain read port. The block presents an address and a read/write level from registers at the start of a cycle. Read data must be valid before the closing edge of that same cycle, which is when the sequencer samples it. On a write cycle the memory stores the write data at the closing edge. When the run ends, the block pulses `done` and shows the advanced program counter. It also shows zero and negative flags computed from the stored result.

Top module: `incr_rmw_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy` and `done` are 0, `bus_rw` is 1, and `bus_addr`, `bus_wdata`, `pc_out`, `flag_z` and `flag_n` are all 0.
- R2: The cycle after an accepted start (start high in an idle cycle) is bus cycle 1. In bus cycles 1, 2 and 3 the block reads (`bus_rw`=1) at `start_pc`, `start_pc`+1 and `start_pc`+2, with addresses wrapping modulo 65536.
- R3: Bus cycle 4 reads at the target address. That address is the byte read in cycle 3 as bits 15:8, joined with the byte read in cycle 2 as bits 7:0.
- R4: Bus cycle 5 is a write (`bus_rw`=0) to the target address, and its write data equals the byte read in cycle 4 unmodified.
- R5: Bus cycle 6 is a write to the target address, and its write data equals the cycle-4 byte plus one, modulo 256 (0xFF gives 0x00).
- R6: `busy` is high for exactly the six bus cycles of a run, each with exactly one access. Read data is sampled at the closing edge of the cycle that shows its address.
- R7: `done` is high for exactly one cycle, the one right after bus cycle 6. From that cycle on, `pc_out` equals `start_pc`+3 modulo 65536.
- R8: A start pulse in any cycle where `busy` is high is ignored. The run keeps its addresses and data, and `pc_out` still ends at the first `start_pc`+3.
- R9: From bus cycle 6 on, `flag_z` is 1 exactly when the incremented byte is 0x00, and `flag_n` equals its bit 7. Both hold their value until the next run's cycle 6.
- R10: The opcode byte read in cycle 1 is not decoded. Any value yields the same six-cycle sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse, honoured only while idle |
| start_pc | input | 16 | Program counter of the instruction to replay |
| bus_rdata | input | 8 | Read data, valid before the closing edge of the cycle |
| bus_addr | output | 16 | Registered bus address |
| bus_wdata | output | 8 | Registered write data |
| bus_rw | output | 1 | 1 = read, 0 = write |
| busy | output | 1 | High during the six bus cycles |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Program counter after the instruction |
| flag_z | output | 1 | Zero flag of the incremented byte |
| flag_n | output | 1 | Negative flag of the incremented byte |

## Verification
The bound checker watches several rules on every cycle. The two writes come as an adjacent pair at one unchanged address. The first write repeats the byte read just before it, and the second carries that value plus one. A run lasts exactly six cycles. `done` stays a single pulse, and `pc_out` lands three past the captured start address. The flags never move on a read cycle. Other properties need the bench's scenarios: that the fetch addresses step and wrap correctly, that the target is assembled little-endian from the fetched operands, and that a start pulse in the middle of a run leaves the bus trace unchanged. Those scenarios also show that arbitrary opcode bytes and the boundary byte values 0xFF and 0x7F give the expected write data and flags.

// File: rtl/incr_rmw_pkg.sv
package incr_rmw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_OPC,
    ST_FETCH_LO,
    ST_FETCH_HI,
    ST_READ_TGT,
    ST_WRITE_ECHO,
    ST_WRITE_INC
  } seq_state_t;
endpackage

// File: rtl/incr_rmw_ctrl.sv
module incr_rmw_ctrl
  import incr_rmw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       accept,
  output seq_state_t state,
  output logic       rw,
  output logic       busy,
  output logic       done
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (accept) state_d = ST_FETCH_OPC;
      ST_FETCH_OPC:  state_d = ST_FETCH_LO;
      ST_FETCH_LO:   state_d = ST_FETCH_HI;
      ST_FETCH_HI:   state_d = ST_READ_TGT;
      ST_READ_TGT:   state_d = ST_WRITE_ECHO;
      ST_WRITE_ECHO: state_d = ST_WRITE_INC;
      ST_WRITE_INC:  state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rw      <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      rw      <= !((state_d == ST_WRITE_ECHO) || (state_d == ST_WRITE_INC));
      busy    <= (state_d != ST_IDLE);
      done    <= (state_q == ST_WRITE_INC);
    end
  end

  assign state = state_q;
endmodule

// File: rtl/incr_rmw_addr.sv
module incr_rmw_addr
  import incr_rmw_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int INSN_LEN = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_state_t    state,
  input  logic          accept,
  input  logic [AW-1:0] start_pc,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] pc_out
);
  localparam int HI_W = AW - DW;

  logic [AW-1:0] base_q;
  logic [DW-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      lo_q   <= '0;
      addr   <= '0;
      pc_out <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          base_q <= start_pc;
          addr   <= start_pc;
        end
        ST_FETCH_OPC: addr <= base_q + AW'(1);
        ST_FETCH_LO: begin
          lo_q <= rdata;
          addr <= base_q + AW'(2);
        end
        ST_FETCH_HI:  addr   <= {rdata[HI_W-1:0], lo_q};
        ST_WRITE_INC: pc_out <= base_q + AW'(INSN_LEN);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/incr_rmw_data.sv
module incr_rmw_data
  import incr_rmw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_state_t    state,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] wdata,
  output logic          flag_z,
  output logic          flag_n
);
  logic [DW-1:0] val_q;
  logic [DW-1:0] inc_val;

  assign inc_val = val_q + DW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q  <= '0;
      wdata  <= '0;
      flag_z <= 1'b0;
      flag_n <= 1'b0;
    end else begin
      unique case (state)
        ST_READ_TGT: begin
          val_q <= rdata;
          wdata <= rdata;
        end
        ST_WRITE_ECHO: begin
          wdata  <= inc_val;
          flag_z <= (inc_val == '0);
          flag_n <= inc_val[DW-1];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/incr_rmw_seq.sv
module incr_rmw_seq
  import incr_rmw_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int INSN_LEN = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_pc,
  input  logic [DW-1:0] bus_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_rw,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] pc_out,
  output logic          flag_z,
  output logic          flag_n
);
  seq_state_t state;
  logic       accept;

  assign accept = (state == ST_IDLE) && start;

  incr_rmw_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .state  (state),
    .rw     (bus_rw),
    .busy   (busy),
    .done   (done)
  );

  incr_rmw_addr #(.AW(AW), .DW(DW), .INSN_LEN(INSN_LEN)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .state    (state),
    .accept   (accept),
    .start_pc (start_pc),
    .rdata    (bus_rdata),
    .addr     (bus_addr),
    .pc_out   (pc_out)
  );

  incr_rmw_data #(.DW(DW)) u_data (
    .clk    (clk),
    .rst    (rst),
    .state  (state),
    .rdata  (bus_rdata),
    .wdata  (bus_wdata),
    .flag_z (flag_z),
    .flag_n (flag_n)
  );
endmodule

// File: rtl/incr_rmw_seq_chk.sv
module incr_rmw_seq_chk #(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int INSN_LEN = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [AW-1:0] start_pc,
  input logic [DW-1:0] bus_rdata,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_rw,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] pc_out,
  input logic          flag_z,
  input logic          flag_n
);
  localparam int RUN_CYCLES = 6;
  localparam int CW = $clog2(RUN_CYCLES + 2);

  logic [CW-1:0] run_len;
  logic [AW-1:0] cap_pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= '0;
      cap_pc  <= '0;
    end else begin
      run_len <= busy ? run_len + CW'(1) : '0;
      if (start && !busy) cap_pc <= start_pc;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!busy && !done && bus_rw && pc_out == '0 && !flag_z && !flag_n)); // R1

  AST_ECHO_WRITE: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_rw) |-> (bus_wdata == $past(bus_rdata) && $stable(bus_addr))); // R4

  AST_INC_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!bus_rw && !$past(bus_rw)) |-> (bus_wdata == DW'($past(bus_wdata) + 1'b1) && $stable(bus_addr))); // R5

  AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_rw) |=> !bus_rw); // R6

  AST_WRITE_END: assert property (@(posedge clk) disable iff (rst)
    (!bus_rw && !$past(bus_rw)) |=> bus_rw); // R6

  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == CW'(RUN_CYCLES))); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !$past(bus_rw))); // R7

  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    done |-> (pc_out == cap_pc + AW'(INSN_LEN))); // R8

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    bus_rw |-> $stable({flag_z, flag_n})); // R9
endmodule

bind incr_rmw_seq incr_rmw_seq_chk #(.AW(AW), .DW(DW), .INSN_LEN(INSN_LEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .start_pc  (start_pc),
  .bus_rdata (bus_rdata),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rw    (bus_rw),
  .busy      (busy),
  .done      (done),
  .pc_out    (pc_out),
  .flag_z    (flag_z),
  .flag_n    (flag_n)
);

// File: tb/tb_incr_rmw_seq.sv
`timescale 1ns/1ps
module tb_incr_rmw_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [15:0] start_pc;
  logic [7:0]  bus_rdata;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_rw, busy, done, flag_z, flag_n;
  logic [15:0] pc_out;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  incr_rmw_seq dut (
    .clk(clk), .rst(rst), .start(start), .start_pc(start_pc),
    .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rw(bus_rw), .busy(busy), .done(done), .pc_out(pc_out),
    .flag_z(flag_z), .flag_n(flag_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_inc(input logic [7:0] v);
    return v + 8'd1;
  endfunction

  // Replays one instruction; poke_cyc (1..6) pulses start mid-run, 0 means none.
  task automatic run_insn(input logic [15:0] pc, input logic [7:0] op, input logic [7:0] lo,
                          input logic [7:0] hi, input logic [7:0] val, input int poke_cyc);
    logic [15:0] tgt;
    logic [15:0] ea;
    logic [7:0]  inc;
    tgt = {hi, lo};
    inc = exp_inc(val);
    start    = 1'b1;
    start_pc = pc;
    @(posedge clk);
    @(negedge clk);
    start    = 1'b0;
    start_pc = ~pc;
    for (int c = 1; c <= 6; c++) begin
      case (c)
        1: ea = pc;
        2: ea = pc + 16'd1;
        3: ea = pc + 16'd2;
        default: ea = tgt;
      endcase
      chk(bus_addr == ea, (c <= 3) ? "R2 fetch address" : "R3 target address", bus_addr, ea);
      chk(bus_rw == (c <= 4), "R2/R6 read-write level", bus_rw, (c <= 4));
      chk(busy == 1'b1, "R6 busy during run", busy, 1);
      if (c == 1) chk(done == 1'b0, "R7 done not stretched", done, 0);
      if (c == 5) chk(bus_wdata == val, "R4 echo write data", bus_wdata, val);
      if (c == 6) begin
        chk(bus_wdata == inc, "R5 incremented write data", bus_wdata, inc);
        chk(flag_z == (inc == 8'h00), "R9 zero flag", flag_z, (inc == 8'h00));
        chk(flag_n == inc[7], "R9 negative flag", flag_n, inc[7]);
      end
      case (c)
        1: bus_rdata = op;
        2: bus_rdata = lo;
        3: bus_rdata = hi;
        4: bus_rdata = val;
        default: bus_rdata = 8'($urandom);
      endcase
      if (c == poke_cyc) begin
        start    = 1'b1;
        start_pc = pc ^ 16'h5A5A;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(done == 1'b1, "R7 done pulse", done, 1);
    chk(busy == 1'b0, "R6 busy ends after six cycles", busy, 0);
    chk(bus_rw == 1'b1, "R6 read level after run", bus_rw, 1);
    chk(pc_out == pc + 16'd3, (poke_cyc != 0) ? "R8 pc after ignored start" : "R7 pc advance",
        pc_out, pc + 16'd3);
    chk(flag_z == (inc == 8'h00), "R9 zero flag held", flag_z, (inc == 8'h00));
    chk(flag_n == inc[7], "R9 negative flag held", flag_n, inc[7]);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst       = 1'b1;
    start     = 1'b0;
    start_pc  = '0;
    bus_rdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 idle in reset", {busy, done}, 0);
    chk(bus_rw == 1'b1, "R1 read level in reset", bus_rw, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_addr == 16'h0 && bus_wdata == 8'h0, "R1 bus cleared", {bus_addr, bus_wdata}, 0);
    chk(pc_out == 16'h0 && !flag_z && !flag_n, "R1 pc and flags cleared", {pc_out, flag_z, flag_n}, 0);
    chk(busy == 1'b0, "R1 busy low after reset", busy, 0);

    // Directed corner cases
    run_insn(16'h1234, 8'hEE, 8'h20, 8'hD0, 8'hF6, 0);
    run_insn(16'hFFFE, 8'hEE, 8'h00, 8'h40, 8'hFF, 0);   // R2 wrap, R5 wrap, R9 zero
    run_insn(16'h0400, 8'hEE, 8'h10, 8'h02, 8'h7F, 0);   // R9 negative
    run_insn(16'h2000, 8'hEE, 8'h34, 8'h12, 8'h00, 2);   // R8 start in cycle 2
    run_insn(16'h3000, 8'hEE, 8'hCD, 8'hAB, 8'h80, 6);   // R8 start in cycle 6
    run_insn(16'h5000, 8'h00, 8'hFF, 8'hFF, 8'h41, 4);   // R10 other opcode, R8

    repeat (3) begin
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R7 quiet without start", {busy, done}, 0);
    end

    // Constrained random runs
    for (int i = 0; i < 40; i++) begin
      logic [7:0] op;
      op = (($urandom % 4) == 0) ? 8'($urandom) : 8'hEE;   // R10
      run_insn(16'($urandom), op, 8'($urandom), 8'($urandom), 8'($urandom),
               int'($urandom % 10));
    end

    @(negedge clk);
    chk(done == 1'b0, "R7 done single cycle", done, 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule